// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Unit

This block multiplies one signed 16-bit half of a first operand word by one signed 16-bit half of a second operand word. A separate select bit for each operand chooses its top or bottom half. The 32-bit product is either returned as it is (multiply mode) or added to a 32-bit addend (accumulate mode). The result appears one cycle after the operation is issued, together with a valid strobe. Another stage of the pipeline decides whether the operation's condition holds and passes that decision in on `cond_pass`. The block does not evaluate conditions itself.

An accumulate whose signed addition overflows sets a sticky flag. The flag stays set until software writes it through the flag port. Neither operation produces or changes any other status flag. A small two-state controller sequences the output:

- **ST_IDLE**: no result is being presented.
- **ST_RESULT**: the result register holds the outcome of the operation accepted on the previous edge.

The transitions are as follows:

- **T_ACCEPT**: from either state to ST_RESULT, when `op_valid` and `cond_pass` are both high.
- **T_QUIET**: from either state to ST_IDLE, in every other case.

Top module: `hsmac_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is 0 and `q_flag` is 0.
- R2: `sel_a_hi` = 0 picks `opnd_a[15:0]` and `sel_a_hi` = 1 picks `opnd_a[31:16]` as the first signed 16-bit factor.
- R3: `sel_b_hi` = 0 picks `opnd_b[15:0]` and `sel_b_hi` = 1 picks `opnd_b[31:16]` as the second signed 16-bit factor.
- R4: With `acc_mode` = 0, an accepted operation presents the signed 32-bit product of the two factors on `res_data` one cycle later.
- R5: With `acc_mode` = 1, an accepted operation presents (product + `addend`) modulo 2^32 one cycle later, with no saturation.
- R6: In an accepted accumulate, signed overflow of the addition sets `q_flag` on the following cycle. Signed overflow means the product and the addend have the same sign and the sum has the opposite sign.
- R7: `q_flag` is sticky. No arithmetic operation clears it. Only a write with `q_wr_en` = 1 loads `q_wr_data` into it.
- R8: Multiply mode never changes `q_flag`. The case -32768 × -32768 yields 0x40000000.
- R9: When `cond_pass` = 0 or `op_valid` = 0, the cycle that follows has `res_valid` = 0. In that case `res_data` keeps its previous value and the arithmetic does not touch `q_flag`.
- R10: When an overflow set and a flag write happen in the same cycle, the flag ends up set.
- R11: `res_valid` is high for exactly the one cycle after each accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an operation this cycle |
| cond_pass | input | 1 | Condition holds; the operation takes effect |
| acc_mode | input | 1 | 0 = multiply only, 1 = multiply and add addend |
| sel_a_hi | input | 1 | Half select for the first operand |
| sel_b_hi | input | 1 | Half select for the second operand |
| opnd_a | input | 32 | First operand word |
| opnd_b | input | 32 | Second operand word |
| addend | input | 32 | Value added in accumulate mode |
| res_data | output | 32 | Registered result |
| res_valid | output | 1 | Result strobe, one cycle after acceptance |
| q_wr_en | input | 1 | Write the sticky flag |
| q_wr_data | input | 1 | Value written to the sticky flag |
| q_flag | output | 1 | Sticky accumulate overflow flag |

## Verification
The bench builds the unit with its default 32-bit data width, so each factor is a true 16-bit signed half. At that width the extreme factor -32768 and the overflow boundaries at ±2^31 can be reached directly, and the bench drives them on purpose. Random operands then cover all four half-select combinations in both modes and with the condition both true and false. Flag writes are mixed into the random stream, so the sticky behaviour and the priority of set over write are exercised alongside ordinary traffic.

// File: rtl/hsmac_pkg.sv
package hsmac_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } hsmac_state_t;

    typedef enum logic [0:0] {
        MODE_MUL = 1'b0,
        MODE_ACC = 1'b1
    } hsmac_mode_t;

endpackage

// File: rtl/hsmac_halfsel.sv
module hsmac_halfsel #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              sel_hi_i,
    output logic [HALF_W-1:0] half_o
);

    always_comb begin
        if (sel_hi_i) half_o = word_i[DATA_W-1:HALF_W];
        else          half_o = word_i[HALF_W-1:0];
    end

endmodule

// File: rtl/hsmac_mul.sv
module hsmac_mul #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [HALF_W-1:0] fa_i,
    input  logic [HALF_W-1:0] fb_i,
    output logic [DATA_W-1:0] prod_o
);

    logic signed [DATA_W-1:0] prod_s;

    always_comb begin
        prod_s = $signed(fa_i) * $signed(fb_i);
        prod_o = prod_s;
    end

    // the product of two halves never carries its two top bits apart
    always_comb begin
        assert (prod_o[DATA_W-1] == prod_o[DATA_W-2] || prod_o == {2'b01, {(DATA_W-2){1'b0}}})
            else $error("AST_PRODUCT_FITS violated"); // R8
    end

endmodule

// File: rtl/hsmac_acc.sv
module hsmac_acc #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] prod_i,
    input  logic [DATA_W-1:0] addend_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);

    logic sp, sa, ss;

    always_comb begin
        sum_o = prod_i + addend_i;
        sp    = prod_i[DATA_W-1];
        sa    = addend_i[DATA_W-1];
        ss    = sum_o[DATA_W-1];
        ovf_o = (sp == sa) && (ss != sp);
    end

endmodule

// File: rtl/hsmac_qflag.sv
module hsmac_qflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en_i,
    input  logic wr_data_i,
    output logic q_o
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= 1'b0;
        else if (set_i)   q_r <= 1'b1;
        else if (wr_en_i) q_r <= wr_data_i;
    end

    assign q_o = q_r;

    AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r && !wr_en_i) |=> q_r); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && wr_en_i) |=> q_r); // R10
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_r && !set_i && !wr_en_i) |=> !q_r); // R6

endmodule

// File: rtl/hsmac_unit.sv
module hsmac_unit #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              cond_pass,
    input  logic              acc_mode,
    input  logic              sel_a_hi,
    input  logic              sel_b_hi,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] addend,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    input  logic              q_wr_en,
    input  logic              q_wr_data,
    output logic              q_flag
);

    import hsmac_pkg::*;

    hsmac_state_t       state, state_nx;
    hsmac_mode_t        mode;
    logic               fire;
    logic [HALF_W-1:0]  half_a, half_b;
    logic [DATA_W-1:0]  prod, sum, res_r;
    logic               ovf, q_set;

    hsmac_halfsel #(.DATA_W(DATA_W)) u_sel_a (
        .word_i(opnd_a), .sel_hi_i(sel_a_hi), .half_o(half_a));
    hsmac_halfsel #(.DATA_W(DATA_W)) u_sel_b (
        .word_i(opnd_b), .sel_hi_i(sel_b_hi), .half_o(half_b));

    hsmac_mul #(.DATA_W(DATA_W)) u_mul (
        .fa_i(half_a), .fb_i(half_b), .prod_o(prod));

    hsmac_acc #(.DATA_W(DATA_W)) u_acc (
        .prod_i(prod), .addend_i(addend), .sum_o(sum), .ovf_o(ovf));

    always_comb begin
        fire  = op_valid && cond_pass;
        mode  = acc_mode ? MODE_ACC : MODE_MUL;
        q_set = fire && (mode == MODE_ACC) && ovf;
    end

    hsmac_qflag u_q (
        .clk(clk), .rst_n(rst_n), .set_i(q_set),
        .wr_en_i(q_wr_en), .wr_data_i(q_wr_data), .q_o(q_flag));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE:   state_nx = fire ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = fire ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) res_r <= '0;
        else if (fire) begin
            unique case (mode)
                MODE_MUL: res_r <= prod;
                MODE_ACC: res_r <= sum;
                default:  res_r <= prod;
            endcase
        end
    end

    // output process
    always_comb begin
        res_data  = res_r;
        res_valid = 1'b0;
        unique case (state)
            ST_IDLE:   res_valid = 1'b0;
            ST_RESULT: res_valid = 1'b1;
            default:   res_valid = 1'b0;
        endcase
    end

    AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cond_pass) |=> res_valid); // R11
    AST_NO_VALID_WITHOUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && cond_pass) |=> !res_valid); // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && cond_pass) |=> $stable(res_data)); // R9
    AST_MUL_KEEPS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_mode && !q_wr_en) |=> $stable(q_flag)); // R8
    AST_SKIP_KEEPS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_pass && !q_wr_en) |=> $stable(q_flag)); // R9

endmodule

// File: tb/sim_hsmac_unit.sv
module sim_hsmac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, cond_pass = 1'b0, acc_mode = 1'b0;
    logic        sel_a_hi = 1'b0, sel_b_hi = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, addend = '0;
    logic [31:0] res_data;
    logic        res_valid;
    logic        q_wr_en = 1'b0, q_wr_data = 1'b0;
    logic        q_flag;

    int checks = 0;
    int errors = 0;
    logic        q_m = 1'b0;
    logic [31:0] last_res = '0;

    always #10 clk = ~clk;

    hsmac_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_pass(cond_pass),
        .acc_mode(acc_mode), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .addend(addend),
        .res_data(res_data), .res_valid(res_valid),
        .q_wr_en(q_wr_en), .q_wr_data(q_wr_data), .q_flag(q_flag));

    function automatic logic signed [31:0] ref_prod(logic [31:0] a, logic [31:0] b,
                                                     logic sa, logic sb);
        logic signed [15:0] ha, hb;
        ha = sa ? a[31:16] : a[15:0];
        hb = sb ? b[31:16] : b[15:0];
        return 32'(int'(ha) * int'(hb));
    endfunction

    function automatic logic ref_ovf(logic signed [31:0] p, logic signed [31:0] c);
        longint s;
        s = longint'(p) + longint'(c);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic check(logic ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic sa, logic sb, logic acc, logic vld, logic cp,
                         logic qwe, logic qwd, string tag);
        logic signed [31:0] p;
        logic [31:0] exp_r;
        logic set;
        p     = ref_prod(a, b, sa, sb);
        exp_r = acc ? (p + c) : p;
        set   = vld && cp && acc && ref_ovf(p, $signed(c));
        opnd_a = a; opnd_b = b; addend = c; sel_a_hi = sa; sel_b_hi = sb;
        acc_mode = acc; op_valid = vld; cond_pass = cp; q_wr_en = qwe; q_wr_data = qwd;
        @(negedge clk);
        op_valid = 1'b0; q_wr_en = 1'b0;
        if (set) q_m = 1'b1;
        else if (qwe) q_m = qwd;
        if (vld && cp) begin
            check(res_valid == 1'b1, tag, "valid", {31'b0, res_valid}, 32'd1);
            check(res_data == exp_r, tag, "data", res_data, exp_r);
            last_res = exp_r;
        end else begin
            check(res_valid == 1'b0, tag, "valid", {31'b0, res_valid}, 32'd0);
            check(res_data == last_res, tag, "hold", res_data, last_res);
        end
        check(q_flag == q_m, tag, "q", {31'b0, q_flag}, {31'b0, q_m});
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'h1234_5678);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0, "R1", "valid", {31'b0, res_valid}, 32'd0);
        check(res_data == 32'd0, "R1", "data", res_data, 32'd0);
        check(q_flag == 1'b0, "R1", "q", {31'b0, q_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3 half selection, distinct halves
        do_op(32'h0003_0005, 32'h0007_000B, 0, 1'b0, 1'b0, 1'b0, 1, 1, 0, 0, "R2");
        do_op(32'h0003_0005, 32'h0007_000B, 0, 1'b1, 1'b0, 1'b0, 1, 1, 0, 0, "R2");
        do_op(32'h0003_0005, 32'h0007_000B, 0, 1'b0, 1'b1, 1'b0, 1, 1, 0, 0, "R3");
        do_op(32'hFFFE_0005, 32'h0007_FFFD, 0, 1'b1, 1'b1, 1'b0, 1, 1, 0, 0, "R3");
        // R4 signed product, negative factors
        do_op(32'h0000_FFFF, 32'h0000_8000, 0, 0, 0, 0, 1, 1, 0, 0, "R4");
        // R8 extreme product, no flag
        do_op(32'h8000_0000, 32'h0000_8000, 0, 1, 0, 0, 1, 1, 0, 0, "R8");
        check(res_data == 32'h4000_0000, "R8", "extreme", res_data, 32'h4000_0000);
        // R11 idle cycle
        do_op(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R11");
        // R5 wrap accumulate without overflow
        do_op(32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFF0, 0, 0, 1, 1, 1, 0, 0, "R5");
        // R9 overflow stimulus skipped by condition
        do_op(32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, 0, 0, "R9");
        // R6 positive overflow sets flag
        do_op(32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 1, 1, 1, 0, 0, "R6");
        check(q_flag == 1'b1, "R6", "set", {31'b0, q_flag}, 32'd1);
        // R7 sticky across non-overflow ops
        do_op(32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 0, 0, 1, 1, 1, 0, 0, "R7");
        do_op(32'h0000_8000, 32'h0000_8000, 0, 0, 0, 0, 1, 1, 0, 0, "R8");
        // R7 explicit clear
        do_op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
        check(q_flag == 1'b0, "R7", "clear", {31'b0, q_flag}, 32'd0);
        // R6 negative overflow
        do_op(32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 0, 0, 1, 1, 1, 0, 0, "R6");
        // R10 set and clear together
        do_op(32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 1, 1, 1, 1, 0, "R10");
        check(q_flag == 1'b1, "R10", "set wins", {31'b0, q_flag}, 32'd1);
        do_op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb, rc;
            logic [7:0] ctl;
            ra = $urandom(); rb = $urandom(); rc = $urandom(); ctl = 8'($urandom());
            if (ctl[7:6] == 2'b00) rc = {rc[31], {31{~rc[31]}}};
            do_op(ra, rb, rc, ctl[0], ctl[1], ctl[2], ctl[3] | ctl[4], ctl[5] | ctl[4],
                  (ctl[7:5] == 3'b111), ctl[6], ctl[2] ? "R5" : "R4");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule